// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block chooses which of up to 60 interrupt sources is served next, and decides whether that source may cut into the handler that is already running. Each source supplies a pending flag, an enable flag and a 4-bit priority code. On every cycle the block compares the codes of all sources that are both pending and enabled. A lower code is more urgent, and code 0 is the most urgent. Sources with equal codes are ordered by interrupt number, and the lower number wins.

A 3-bit split field divides the 4-bit code at run time. The upper part is the nesting level and the lower part is a tie-break rank. Only the nesting level can interrupt a running handler. The block keeps a stack of nesting levels that have been entered. When the processor accepts an interrupt (`ack` while `take_req` is high), the winner's nesting level is pushed onto the stack. When a handler returns (`ret`), the top level is popped. The current running level is always visible on `run_prio`.

Top module: `irq_nest_arbiter`

## Requirements
- R1: While reset is low, and on the first cycle after reset, `take_req` is 0, `win_id` is 0 and `run_prio` is 16, which is the idle value.
- R2: Among sources k that have both `irq_pend[k]` and `irq_en[k]` set, the winner is the source with the smallest 4-bit code `prio_vec[4k+3:4k]`. Its number appears on `win_id`.
- R3: When two or more eligible sources have equal codes, the one with the lowest interrupt number wins.
- R4: A source that is not pending, or not enabled, is never chosen. When no source is eligible, `take_req` is 0 and `win_id` is 0.
- R5: The split field gives P nesting bits. P is 7 minus `grp_split` for values 3 to 7, so 3 gives 4 bits and 7 gives 0 bits. Values 0 to 2 also give P = 4. The nesting level is the winner's code with its low 4-P bits forced to 0.
- R6: `take_req` is 1 only if the winner's nesting level is strictly less than `run_prio`. When the block is idle (`run_prio` is 16), any eligible winner is taken.
- R7: A winner whose nesting level equals the running level is not taken, even when its full code is smaller.
- R8: Outputs are registered. `take_req`, `win_id` and `run_prio` reflect the inputs sampled at the previous rising edge, and a change at the inputs does not show at the outputs before that edge.
- R9: `ack` in a cycle where `take_req` is 1 pushes the registered winner's nesting level. On the next cycle `run_prio` equals that level and `take_req` is 0. `ack` while `take_req` is 0 has no effect.
- R10: `ret` pops the stack, and `run_prio` returns to the previous nesting level, or to 16 when the stack becomes empty. `ret` on an empty stack has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pend | input | 60 | Pending flag for each source |
| irq_en | input | 60 | Enable flag for each source |
| prio_vec | input | 240 | 4-bit priority code for each source; source k uses bits 4k+3:4k |
| grp_split | input | 3 | Split between nesting bits and tie-break bits |
| ack | input | 1 | Processor accepts the offered interrupt |
| ret | input | 1 | Running handler returns |
| take_req | output | 1 | Request to enter the handler of `win_id` |
| win_id | output | 6 | Number of the winning source |
| run_prio | output | 5 | Current running nesting level; 16 means idle |

## Verification
The bench aims at equal codes on several sources. A design that broke ties wrongly would report the higher-numbered source. It also aims at winners whose nesting level matches the running level but whose tie-break bits are smaller. A design that compared full codes when deciding on preemption would nest there when it should not.

Each split setting is exercised, including setting 7, where nothing can nest, and the settings below 3. A wrong decode would mask the wrong bits and take or refuse the wrong winners. Returns from handlers are driven down to an empty stack and then once more. A wrong stack would restore the wrong level or leave idle. The bench also drives `ack` while nothing is offered, where a faulty design would push a level that was never taken.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int PRIO_W  = 4;
    localparam int GRP_W   = 3;
    localparam int LVL_W   = PRIO_W + 1;
    localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(1) << PRIO_W;

    // number of nesting bits taken from the top of the code
    function automatic int nest_bits(input logic [GRP_W-1:0] grp);
        int g;
        g = int'(grp);
        return (g >= 3) ? (7 - g) : PRIO_W;
    endfunction

    // keeps the nesting bits, clears the tie-break bits
    function automatic logic [PRIO_W-1:0] nest_mask(input logic [GRP_W-1:0] grp);
        int low;
        low = PRIO_W - nest_bits(grp);
        return PRIO_W'(~((1 << low) - 1));
    endfunction
endpackage

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
    parameter int N  = 60,
    parameter int PW = 4,
    parameter int IW = 6
) (
    input  logic [N-1:0]    elig,
    input  logic [N*PW-1:0] prio,
    output logic            best_vld,
    output logic [PW-1:0]   best_prio,
    output logic [IW-1:0]   best_id
);
    localparam int LEAVES = 1 << $clog2(N);
    localparam int NODES  = 2 * LEAVES;

    logic          node_v [1:NODES-1];
    logic [PW-1:0] node_p [1:NODES-1];
    logic [IW-1:0] node_i [1:NODES-1];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign node_v[LEAVES+k] = elig[k];
            assign node_p[LEAVES+k] = prio[k*PW +: PW];
            assign node_i[LEAVES+k] = IW'(k);
        end else begin : g_pad
            assign node_v[LEAVES+k] = 1'b0;
            assign node_p[LEAVES+k] = '0;
            assign node_i[LEAVES+k] = '0;
        end
    end

    // left child always holds lower numbers, so ties go left
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic pick_r;
        assign pick_r = node_v[2*n+1] &&
                        (!node_v[2*n] || (node_p[2*n+1] < node_p[2*n]));
        assign node_v[n] = node_v[2*n] | node_v[2*n+1];
        assign node_p[n] = pick_r ? node_p[2*n+1] : node_p[2*n];
        assign node_i[n] = pick_r ? node_i[2*n+1] : node_i[2*n];
    end

    assign best_vld  = node_v[1];
    assign best_prio = node_p[1];
    assign best_id   = node_i[1];
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
    parameter int               DEPTH     = 16,
    parameter int               LW        = 5,
    parameter logic [LW-1:0]    EMPTY_LVL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] push_lvl,
    output logic [LW-1:0] top_lvl
);
    localparam int DW = $clog2(DEPTH + 1);

    logic [LW-1:0] mem_d [DEPTH];
    logic [LW-1:0] mem_q [DEPTH];
    logic [DW-1:0] dep_d, dep_q;

    always_comb begin
        mem_d = mem_q;
        dep_d = dep_q;
        if (pop && (dep_q != '0)) begin
            dep_d = dep_q - 1'b1;
        end
        if (push && (dep_d != DW'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (DW'(i) == dep_d) begin
                    mem_d[i] = push_lvl;
                end
            end
            dep_d = dep_d + 1'b1;
        end
    end

    always_comb begin
        top_lvl = EMPTY_LVL;
        for (int i = 0; i < DEPTH; i++) begin
            if (DW'(i + 1) == dep_q) begin
                top_lvl = mem_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dep_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            dep_q <= dep_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_pend,
    input  logic [NUM_SRC-1:0]        irq_en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
    input  logic [GRP_W-1:0]          grp_split,
    input  logic                      ack,
    input  logic                      ret,
    output logic                      take_req,
    output logic [$clog2(NUM_SRC)-1:0] win_id,
    output logic [LVL_W-1:0]          run_prio
);
    localparam int ID_W       = $clog2(NUM_SRC);
    localparam int NEST_DEPTH = 1 << PRIO_W;

    typedef struct packed {
        logic              take;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] lvl;
    } sel_t;

    sel_t sel_d, sel_q;

    logic [NUM_SRC-1:0] elig;
    logic               tree_vld;
    logic [PRIO_W-1:0]  tree_prio;
    logic [ID_W-1:0]    tree_id;
    logic [PRIO_W-1:0]  win_lvl;
    logic [LVL_W-1:0]   run_lvl;
    logic [PRIO_W-1:0]  held_lvl;
    logic               push;

    assign elig = irq_pend & irq_en;

    irq_prio_tree #(
        .N  (NUM_SRC),
        .PW (PRIO_W),
        .IW (ID_W)
    ) u_tree (
        .elig      (elig),
        .prio      (prio_vec),
        .best_vld  (tree_vld),
        .best_prio (tree_prio),
        .best_id   (tree_id)
    );

    irq_nest_stack #(
        .DEPTH     (NEST_DEPTH),
        .LW        (LVL_W),
        .EMPTY_LVL (LVL_IDLE)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (ret),
        .push_lvl ({1'b0, held_lvl}),
        .top_lvl  (run_lvl)
    );

    assign held_lvl = sel_q.lvl;
    assign push     = ack && sel_q.take;

    always_comb begin
        win_lvl    = tree_prio & nest_mask(grp_split);
        sel_d      = '0;
        sel_d.take = tree_vld && ({1'b0, win_lvl} < run_lvl) && !push;
        if (tree_vld) begin
            sel_d.id  = tree_id;
            sel_d.lvl = win_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign take_req = sel_q.take;
    assign win_id   = sel_q.id;
    assign run_prio = run_lvl;
endmodule

// File: rtl/irq_nest_arbiter_chk.sv
module irq_nest_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 60
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ack,
    input logic                       ret,
    input logic                       take_req,
    input logic [$clog2(NUM_SRC)-1:0] win_id,
    input logic [LVL_W-1:0]           run_prio,
    input logic [PRIO_W-1:0]          held_lvl
);
    // R1
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_prio <= LVL_IDLE);

    // R4
    id_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> (int'(win_id) < NUM_SRC));

    // R6
    take_urgent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |-> ({1'b0, held_lvl} < run_prio));

    // R9
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && take_req) |=> ((run_prio == {1'b0, $past(held_lvl)}) && !take_req));

    // R10
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !(ack && take_req)) |=> (run_prio >= $past(run_prio)));

    // R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret && !(ack && take_req)) |=> $stable(run_prio));
endmodule

bind irq_nest_arbiter irq_nest_arbiter_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .ret      (ret),
    .take_req (take_req),
    .win_id   (win_id),
    .run_prio (run_prio),
    .held_lvl (held_lvl)
);

// File: tb/test_irq_nest_arbiter.sv
`timescale 1ns/1ps
module test_irq_nest_arbiter;
    localparam int NS = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_pend = '0;
    logic [NS-1:0] irq_en = '0;
    logic [NS*4-1:0] prio_vec = '0;
    logic [2:0]    grp_split = '0;
    logic          ack = 1'b0;
    logic          ret = 1'b0;
    logic          take_req;
    logic [5:0]    win_id;
    logic [4:0]    run_prio;

    irq_nest_arbiter #(.NUM_SRC(NS)) i_irq_nest_arbiter (
        .clk, .rst_n, .irq_pend, .irq_en, .prio_vec, .grp_split,
        .ack, .ret, .take_req, .win_id, .run_prio
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // stimulus state
    logic [3:0]    pv [NS];
    logic [NS-1:0] pend_v, en_v;
    logic [2:0]    grp_v;
    logic          ack_v, ret_v;

    // reference model
    logic [4:0] m_stk [16];
    int         m_dep = 0;
    logic       e_take = 1'b0;
    int         e_id = 0;
    logic [3:0] e_lvl = '0;

    function automatic logic [4:0] m_run();
        return (m_dep == 0) ? 5'd16 : m_stk[m_dep-1];
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "take_req", int'(take_req), int'(e_take));
        chk(tag, "win_id",   int'(win_id),   e_id);
        chk(tag, "run_prio", int'(run_prio), int'(m_run()));
    endtask

    // drive one cycle of inputs, advance the model, check after the edge
    task automatic step(string tag, bit pre_chk = 1'b0);
        int         best;
        int         pre;
        logic [3:0] lvl;
        logic [3:0] mk;
        logic [4:0] run_old;
        logic       push;
        irq_pend  = pend_v;
        irq_en    = en_v;
        grp_split = grp_v;
        ack       = ack_v;
        ret       = ret_v;
        for (int k = 0; k < NS; k++) prio_vec[k*4 +: 4] = pv[k];
        if (pre_chk) begin
            #1;
            check_all(tag);
        end
        run_old = m_run();
        push    = ack_v && e_take;
        best    = -1;
        for (int k = 0; k < NS; k++) begin
            if (pend_v[k] && en_v[k] && (best < 0 || pv[k] < pv[best])) best = k;
        end
        pre = (int'(grp_v) >= 3) ? 7 - int'(grp_v) : 4;
        mk  = 4'(4'hF << (4 - pre));
        lvl = (best >= 0) ? (pv[best] & mk) : 4'd0;
        if (ret_v && m_dep > 0) m_dep--;
        if (push && m_dep < 16) begin
            m_stk[m_dep] = {1'b0, e_lvl};
            m_dep++;
        end
        e_take = (best >= 0) && ({1'b0, lvl} < run_old) && !push;
        e_id   = (best >= 0) ? best : 0;
        e_lvl  = lvl;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic clr();
        pend_v = '0; en_v = '1; ack_v = 0; ret_v = 0;
        for (int k = 0; k < NS; k++) pv[k] = 4'hF;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clr();
        grp_v = 3'd3;
        repeat (3) @(negedge clk);
        check_all("R1");                       // R1 in reset
        rst_n = 1'b1;
        pend_v = '0; en_v = '0;
        step("R1");                            // R1 first cycle after reset

        // R3 tie: 5, 9, 40 share code 3
        clr(); grp_v = 3'd3;
        pv[5] = 3; pv[9] = 3; pv[40] = 3;
        pend_v[5] = 1; pend_v[9] = 1; pend_v[40] = 1;
        step("R3");
        // R4 disabled source dropped, then nothing enabled
        en_v[5] = 0;
        step("R4");
        en_v = '0;
        step("R4");
        // R2 smaller code wins over lower number
        en_v = '1; pend_v = '0; pend_v[9] = 1; pend_v[20] = 1; pv[20] = 1;
        step("R2");
        // R8 input change must not appear before the edge
        clr(); step("R8");
        pend_v[30] = 1; pv[30] = 2;
        step("R8", 1'b1);

        // R5 two nesting bits, push level 4
        clr(); grp_v = 3'd5; pv[9] = 6; pend_v[9] = 1;
        step("R5");
        ack_v = 1; step("R9");
        ack_v = 0; pend_v[9] = 0; step("R9");
        // R7 same nesting level, smaller full code: no nesting
        pv[3] = 7; pend_v[3] = 1; step("R7");
        pv[3] = 4; step("R7");
        // R6 more urgent level nests
        pv[3] = 3; step("R6");
        ack_v = 1; step("R9");
        ack_v = 0; pend_v = '0; step("R9");
        ack_v = 1; step("R9");                 // R9 ack with nothing offered
        ack_v = 0;
        // R10 unwind to idle, then extra return ignored
        ret_v = 1; step("R10"); step("R10"); step("R10");
        ret_v = 0;

        // R5 split 7: no nesting bits at all
        clr(); grp_v = 3'd7; pv[12] = 9; pend_v[12] = 1;
        step("R5");
        ack_v = 1; step("R5");
        ack_v = 0; pend_v = '0; pend_v[2] = 1; pv[2] = 0; step("R7");
        ret_v = 1; pend_v = '0; step("R10");
        ret_v = 0;

        // R5 split 1 behaves as four nesting bits
        clr(); grp_v = 3'd1; pv[12] = 9; pend_v[12] = 1;
        step("R5");
        ack_v = 1; step("R5");
        ack_v = 0; pend_v = '0; pend_v[2] = 1; pv[2] = 8; step("R5");
        ack_v = 1; step("R5");
        ack_v = 0; pend_v = '0; ret_v = 1; step("R10"); step("R10");
        ret_v = 0;

        // random mix: selection, preemption and nesting together
        for (int n = 0; n < 1500; n++) begin
            pend_v = NS'({$urandom, $urandom} & {$urandom, $urandom});
            en_v   = NS'(~({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
            grp_v  = 3'($urandom);
            for (int k = 0; k < NS; k++) pv[k] = 4'($urandom);
            ack_v  = ($urandom % 3) == 0;
            ret_v  = ($urandom % 5) == 0;
            step("R2_R6_R10");
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule